// File: doc/BRIEF.md
# Half-Bridge Dead-Time Controller

This block converts one logic-level PWM command into two complementary gate enables for a half-bridge: a high-side enable that follows the command and a low-side enable that follows its inverse. Each change of the command first switches off the side that was conducting, waits a programmed propagation delay, then waits a programmed dead time before switching on the opposite side. All four delays are counted in clock cycles, and each edge direction has its own pair. Two switches of one leg are therefore never enabled together in normal operation.

A fault injector can be armed at any chosen moment to test the surrounding system. Once it is armed, it either pins the command seen by the sequencer to a constant level or forces one or both gate enables to a fixed value. It then stays in force until reset.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: During reset, and after reset until the first change of the sampled command, both `gate_hi` and `gate_lo` are 0, even if `pwm_in` is held at 1 through and after reset.
- R2: A 0-to-1 command sampled at clock edge E drives `gate_lo` to 0 from edge E+`cfg_rise_lo_dly` (it stays 1 until then only if it was 1 at E) and drives `gate_hi` to 1 from edge E+`cfg_rise_lo_dly`+`cfg_rise_hi_dead`.
- R3: A 1-to-0 command sampled at clock edge E drives `gate_hi` to 0 from edge E+`cfg_fall_hi_dly` (it stays 1 until then only if it was 1 at E) and drives `gate_lo` to 1 from edge E+`cfg_fall_hi_dly`+`cfg_fall_lo_dead`.
- R4: The pair of timing values for a direction is captured at the edge that uses it. Changing the configuration inputs while a sequence is running has no effect on that sequence.
- R5: A command change that arrives before a sequence completes abandons that sequence. The side the new edge switches on goes to 0 immediately, and the new sequence then runs from its own start under R2 or R3.
- R6: With no fault active, `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R7: A cycle with `flt_arm`=1 and `flt_enable`=1 latches `flt_code`, and the fault takes effect from the following cycle. An arm with `flt_enable`=0 is ignored. Once a fault is active, later arms are ignored and the fault holds until reset.
- R8: Code 0 pins the sequencer's command to 0 and code 1 pins it to 1. `pwm_in` is then ignored, and the outputs follow the pinned command through R2 and R3.
- R9: Code 2 forces `gate_hi`=0, code 3 forces `gate_hi`=1, code 4 forces `gate_lo`=0, code 5 forces `gate_lo`=1, code 6 forces both to 0 and code 7 forces both to 1. A side that is not forced keeps following the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_in | input | 1 | PWM command (1 = high side conducts) |
| cfg_rise_lo_dly | input | CNT_W | Cycles from a rising command to low-side off |
| cfg_rise_hi_dead | input | CNT_W | Further cycles before high-side on |
| cfg_fall_hi_dly | input | CNT_W | Cycles from a falling command to high-side off |
| cfg_fall_lo_dead | input | CNT_W | Further cycles before low-side on |
| flt_code | input | 3 | Fault mode code (see R8, R9) |
| flt_enable | input | 1 | Qualifies `flt_arm` |
| flt_arm | input | 1 | Strobe that activates the selected fault |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
The hardest cases to reach are the abandoned sequences of R5. Here a command edge lands while the opposite side is still inside its propagation delay or its dead time. The stimulus reaches them by cutting the expected-value window of one edge short after a chosen number of cycles, then issuing the opposite edge at once. That edge's expected output is computed from the enable level present at the moment it is sampled. All sixteen combinations of small delay values are swept for both directions, and every fault code is armed from a known conducting state and observed with the command both steady and toggling.

// File: rtl/hb_dt_pkg.sv
// Package: shared types for the half-bridge dead-time controller.
// Assumes: fault codes are a fixed 3-bit encoding decoded by hb_fault_ctl.
package hb_dt_pkg;

    typedef enum logic [2:0] {
        FLT_IN_LO    = 3'd0,
        FLT_IN_HI    = 3'd1,
        FLT_HI_OFF   = 3'd2,
        FLT_HI_ON    = 3'd3,
        FLT_LO_OFF   = 3'd4,
        FLT_LO_ON    = 3'd5,
        FLT_BOTH_OFF = 3'd6,
        FLT_BOTH_ON  = 3'd7
    } flt_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RISE = 2'd1,
        PH_FALL = 2'd2
    } phase_e;

endpackage

// File: rtl/hb_fault_ctl.sv
// Module: hb_fault_ctl
// Latches a fault code on a qualified arm strobe and decodes it into
// command-pinning and output-forcing controls.
// Assumes: the first qualified arm after reset wins; only reset clears it.
module hb_fault_ctl
    import hb_dt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_i,
    input  logic       en_i,
    input  logic [2:0] code_i,
    output logic       active_o,
    output logic       pin_cmd_o,
    output logic       pin_val_o,
    output logic       frc_hi_o,
    output logic       frc_hi_val_o,
    output logic       frc_lo_o,
    output logic       frc_lo_val_o
);

    logic      active_q;
    flt_mode_e mode_q;

    // Capture the fault code once on the first qualified arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            mode_q   <= FLT_IN_LO;
        end else if (arm_i && en_i && !active_q) begin
            active_q <= 1'b1;
            mode_q   <= flt_mode_e'(code_i);
        end
    end

    // Decode the latched code into pinning and forcing controls.
    always_comb begin
        pin_cmd_o    = 1'b0;
        pin_val_o    = 1'b0;
        frc_hi_o     = 1'b0;
        frc_hi_val_o = 1'b0;
        frc_lo_o     = 1'b0;
        frc_lo_val_o = 1'b0;
        if (active_q) begin
            case (mode_q)
                FLT_IN_LO:    begin pin_cmd_o = 1'b1; pin_val_o = 1'b0; end
                FLT_IN_HI:    begin pin_cmd_o = 1'b1; pin_val_o = 1'b1; end
                FLT_HI_OFF:   begin frc_hi_o = 1'b1; frc_hi_val_o = 1'b0; end
                FLT_HI_ON:    begin frc_hi_o = 1'b1; frc_hi_val_o = 1'b1; end
                FLT_LO_OFF:   begin frc_lo_o = 1'b1; frc_lo_val_o = 1'b0; end
                FLT_LO_ON:    begin frc_lo_o = 1'b1; frc_lo_val_o = 1'b1; end
                FLT_BOTH_OFF: begin
                    frc_hi_o = 1'b1; frc_hi_val_o = 1'b0;
                    frc_lo_o = 1'b1; frc_lo_val_o = 1'b0;
                end
                FLT_BOTH_ON:  begin
                    frc_hi_o = 1'b1; frc_hi_val_o = 1'b1;
                    frc_lo_o = 1'b1; frc_lo_val_o = 1'b1;
                end
                default:      begin pin_cmd_o = 1'b0; end
            endcase
        end
    end

    assign active_o = active_q;

    // R7
    property fault_sticky_p;
        @(posedge clk) disable iff (!rst_n) active_q |=> active_q;
    endproperty
    fault_sticky_chk: assert property (fault_sticky_p);

    // R7
    property fault_code_hold_p;
        @(posedge clk) disable iff (!rst_n) active_q |=> $stable(mode_q);
    endproperty
    fault_code_hold_chk: assert property (fault_code_hold_p);

endmodule

// File: rtl/hb_edge_det.sv
// Module: hb_edge_det
// Detects rising and falling changes of the effective command level.
// Assumes: the first cycle after reset only records the level, so a level
// already present at reset release never counts as an edge.
module hb_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);

    logic lvl_q;
    logic valid_q;

    // Remember the previous level and mark it valid after the first sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            lvl_q   <= lvl_i;
            valid_q <= 1'b1;
        end
    end

    assign rise_o = valid_q &&  lvl_i && !lvl_q;
    assign fall_o = valid_q && !lvl_i &&  lvl_q;

endmodule

// File: rtl/hb_dt_seq.sv
// Module: hb_dt_seq
// Runs the propagation-delay / dead-time sequence after each command edge
// with an elapsed-cycle counter compared against two captured thresholds.
// Assumes: rise_i and fall_i are never both 1; thresholds fit in CNT_W bits.
module hb_dt_seq
    import hb_dt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] rise_off_dly_i,
    input  logic [CNT_W-1:0] rise_dead_i,
    input  logic [CNT_W-1:0] fall_off_dly_i,
    input  logic [CNT_W-1:0] fall_dead_i,
    output logic             hi_o,
    output logic             lo_o
);

    localparam int T_W = CNT_W + 1;

    phase_e         phase_q;
    logic [T_W-1:0] t_q;
    logic [T_W-1:0] off_at_q;
    logic [T_W-1:0] on_at_q;
    logic           prior_q;

    // Capture thresholds and the outgoing side's level at each command edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            off_at_q <= '0;
            on_at_q  <= '0;
            prior_q  <= 1'b0;
        end else if (rise_i) begin
            phase_q  <= PH_RISE;
            off_at_q <= {1'b0, rise_off_dly_i};
            on_at_q  <= {1'b0, rise_off_dly_i} + {1'b0, rise_dead_i};
            prior_q  <= lo_o;
        end else if (fall_i) begin
            phase_q  <= PH_FALL;
            off_at_q <= {1'b0, fall_off_dly_i};
            on_at_q  <= {1'b0, fall_off_dly_i} + {1'b0, fall_dead_i};
            prior_q  <= hi_o;
        end
    end

    // Count cycles since the last edge, saturating at the turn-on threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else if (rise_i || fall_i) begin
            t_q <= '0;
        end else if (phase_q != PH_IDLE && t_q < on_at_q) begin
            t_q <= t_q + 1'b1;
        end
    end

    // Derive both enables from the phase and elapsed count.
    always_comb begin
        hi_o = 1'b0;
        lo_o = 1'b0;
        case (phase_q)
            PH_RISE: begin
                hi_o = (t_q >= on_at_q);
                lo_o = prior_q && (t_q < off_at_q);
            end
            PH_FALL: begin
                lo_o = (t_q >= on_at_q);
                hi_o = prior_q && (t_q < off_at_q);
            end
            default: begin
                hi_o = 1'b0;
                lo_o = 1'b0;
            end
        endcase
    end

    // R4
    property thr_hold_p;
        @(posedge clk) disable iff (!rst_n)
            !(rise_i || fall_i) |=> ($stable(off_at_q) && $stable(on_at_q));
    endproperty
    thr_hold_chk: assert property (thr_hold_p);

endmodule

// File: rtl/hb_deadtime_ctrl.sv
// Module: hb_deadtime_ctrl (top)
// Complementary half-bridge gate enable generator with per-direction delay
// and dead time, plus a latched fault injector.
// Assumes: pwm_in is synchronous to clk; reset is synchronous, active low.
module hb_deadtime_ctrl
    import hb_dt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    input  logic [CNT_W-1:0] cfg_rise_lo_dly,
    input  logic [CNT_W-1:0] cfg_rise_hi_dead,
    input  logic [CNT_W-1:0] cfg_fall_hi_dly,
    input  logic [CNT_W-1:0] cfg_fall_lo_dead,
    input  logic [2:0]       flt_code,
    input  logic             flt_enable,
    input  logic             flt_arm,
    output logic             gate_hi,
    output logic             gate_lo
);

    logic flt_active;
    logic pin_cmd, pin_val;
    logic frc_hi, frc_hi_val, frc_lo, frc_lo_val;
    logic cmd_eff;
    logic cmd_rise, cmd_fall;
    logic seq_hi, seq_lo;

    hb_fault_ctl u_fault (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_i        (flt_arm),
        .en_i         (flt_enable),
        .code_i       (flt_code),
        .active_o     (flt_active),
        .pin_cmd_o    (pin_cmd),
        .pin_val_o    (pin_val),
        .frc_hi_o     (frc_hi),
        .frc_hi_val_o (frc_hi_val),
        .frc_lo_o     (frc_lo),
        .frc_lo_val_o (frc_lo_val)
    );

    // Select the command the sequencer sees: live or pinned by a fault.
    always_comb begin
        cmd_eff = pin_cmd ? pin_val : pwm_in;
    end

    hb_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (cmd_eff),
        .rise_o (cmd_rise),
        .fall_o (cmd_fall)
    );

    hb_dt_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .rise_i         (cmd_rise),
        .fall_i         (cmd_fall),
        .rise_off_dly_i (cfg_rise_lo_dly),
        .rise_dead_i    (cfg_rise_hi_dead),
        .fall_off_dly_i (cfg_fall_hi_dly),
        .fall_dead_i    (cfg_fall_lo_dead),
        .hi_o           (seq_hi),
        .lo_o           (seq_lo)
    );

    // Apply output-forcing faults on top of the sequencer enables.
    always_comb begin
        gate_hi = frc_hi ? frc_hi_val : seq_hi;
        gate_lo = frc_lo ? frc_lo_val : seq_lo;
    end

    // R6
    property no_shoot_through_p;
        @(posedge clk) disable iff (!rst_n)
            !flt_active |-> !(gate_hi && gate_lo);
    endproperty
    no_shoot_through_chk: assert property (no_shoot_through_p);

    // R1
    property quiet_after_reset_p;
        @(posedge clk) disable iff (!rst_n)
            $rose(gate_hi) |-> (flt_active || seq_hi);
    endproperty
    quiet_after_reset_chk: assert property (quiet_after_reset_p);

endmodule

// File: tb/tb_hb_deadtime_ctrl.sv
module tb_hb_deadtime_ctrl;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwm_in = 1'b1;
    logic [CNT_W-1:0] cfg_rise_lo_dly = 16'd1;
    logic [CNT_W-1:0] cfg_rise_hi_dead = 16'd1;
    logic [CNT_W-1:0] cfg_fall_hi_dly = 16'd1;
    logic [CNT_W-1:0] cfg_fall_lo_dead = 16'd1;
    logic [2:0]       flt_code = 3'd0;
    logic             flt_enable = 1'b0;
    logic             flt_arm = 1'b0;
    logic             gate_hi, gate_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hb_deadtime_ctrl #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
        .cfg_rise_lo_dly(cfg_rise_lo_dly), .cfg_rise_hi_dead(cfg_rise_hi_dead),
        .cfg_fall_hi_dly(cfg_fall_hi_dly), .cfg_fall_lo_dead(cfg_fall_lo_dead),
        .flt_code(flt_code), .flt_enable(flt_enable), .flt_arm(flt_arm),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    task automatic check(input string tag, input bit exp_hi, input bit exp_lo);
        checks++;
        if (gate_hi !== exp_hi || gate_lo !== exp_lo) begin
            errors++;
            $display("FAIL %s: hi/lo = %b%b, expected %b%b at %0t",
                     tag, gate_hi, gate_lo, exp_hi, exp_lo, $time);
        end
    endtask

    task automatic check_r6();
        checks++;
        if (gate_hi === 1'b1 && gate_lo === 1'b1) begin
            errors++;
            $display("FAIL R6: hi/lo = 11, expected not both 1 at %0t", $time);
        end
    endtask

    // Issue one command edge at a negedge and check nwin cycles after it.
    task automatic edge_run(input bit lvl, input int p, input int d,
                            input bit prior, input int nwin,
                            input bit scramble, input string tag);
        if (lvl) begin
            cfg_rise_lo_dly  = p[CNT_W-1:0];
            cfg_rise_hi_dead = d[CNT_W-1:0];
        end else begin
            cfg_fall_hi_dly  = p[CNT_W-1:0];
            cfg_fall_lo_dead = d[CNT_W-1:0];
        end
        pwm_in = lvl;
        for (int k = 0; k < nwin; k++) begin
            @(negedge clk);
            if (lvl) check(tag, (k >= p + d), prior && (k < p));
            else     check(tag, prior && (k < p), (k >= p + d));
            check_r6();
            if (scramble && k == 0) begin
                cfg_rise_lo_dly  = 16'd9;
                cfg_rise_hi_dead = 16'd9;
                cfg_fall_hi_dly  = 16'd9;
                cfg_fall_lo_dead = 16'd9;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        flt_arm = 1'b0;
        flt_enable = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    // Fault expectations per code: phase A (command 0 steady), B (command 1).
    localparam bit [7:0] A_HI = 8'b1000_1010;
    localparam bit [7:0] A_LO = 8'b1010_1101;
    localparam bit [7:0] B_HI = 8'b1011_1010;
    localparam bit [7:0] B_LO = 8'b1010_0001;

    task automatic fault_case(input int m);
        string tg;
        tg = (m < 2) ? "R8" : "R9";
        pwm_in = 1'b0;
        cfg_rise_lo_dly = 16'd1; cfg_rise_hi_dead = 16'd1;
        cfg_fall_hi_dly = 16'd1; cfg_fall_lo_dead = 16'd1;
        do_reset();
        repeat (3) @(negedge clk);
        pwm_in = 1'b1;
        repeat (5) @(negedge clk);
        pwm_in = 1'b0;
        repeat (5) @(negedge clk);
        check("R3", 1'b0, 1'b1);
        // arm without enable: ignored
        flt_code = 3'd6; flt_enable = 1'b0; flt_arm = 1'b1;
        @(negedge clk);
        check("R7", 1'b0, 1'b1);
        flt_code = m[2:0]; flt_enable = 1'b1;
        @(negedge clk);
        flt_arm = 1'b0; flt_enable = 1'b0;
        repeat (6) @(negedge clk);
        check(tg, A_HI[m], A_LO[m]);
        // second arm with a different code: ignored
        flt_code = m[2:0] ^ 3'd1; flt_enable = 1'b1; flt_arm = 1'b1;
        @(negedge clk);
        flt_arm = 1'b0; flt_enable = 1'b0;
        for (int k = 0; k < 8; k++) begin
            pwm_in = ~pwm_in;
            @(negedge clk);
            if (m < 2) check("R8", A_HI[m], A_LO[m]);
        end
        pwm_in = 1'b1;
        repeat (8) @(negedge clk);
        check(tg, B_HI[m], B_LO[m]);
        check("R7", B_HI[m], B_LO[m]);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit prior_hi;
        // R1: reset with command held high, then no edge
        repeat (2) @(negedge clk);
        check("R1", 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R1", 1'b0, 1'b0);

        // R2/R3 sweep, R4 scrambling on odd combinations
        prior_hi = 1'b0;
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                edge_run(1'b0, (i + 1) % 4, (j + 2) % 4, prior_hi,
                         ((i + 1) % 4) + ((j + 2) % 4) + 3, 1'b0, "R3");
                edge_run(1'b1, i, j, 1'b1, i + j + 3, ((i + j) % 2) == 1,
                         ((i + j) % 2) == 1 ? "R4" : "R2");
                prior_hi = 1'b1;
            end
        end

        // R5: fall abandoned during high-side delay, rise restarts
        edge_run(1'b0, 3, 2, 1'b1, 2, 1'b0, "R5");
        edge_run(1'b1, 2, 1, 1'b0, 6, 1'b0, "R5");
        // R5: fall abandoned during dead time, zero-delay rise
        edge_run(1'b0, 1, 4, 1'b1, 3, 1'b0, "R5");
        edge_run(1'b1, 0, 0, 1'b0, 3, 1'b0, "R5");
        // R5: rise abandoned while low side still on
        edge_run(1'b0, 0, 0, 1'b1, 3, 1'b0, "R3");
        edge_run(1'b1, 3, 1, 1'b1, 2, 1'b0, "R5");
        edge_run(1'b0, 1, 2, 1'b0, 6, 1'b0, "R5");

        // R7, R8, R9: every fault code
        for (int m = 0; m < 8; m++) fault_case(m);

        // R1 again: reset clears the last fault
        pwm_in = 1'b1;
        do_reset();
        repeat (4) @(negedge clk);
        check("R1", 1'b0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule